// File: doc/BRIEF.md
# Buffered-Duty PWM Timer

This block is an up-counting timer that produces a pulse-width-modulated waveform. It counts once for every cycle in which the count-tick input is high and the run input is high. A period compare value sets the length of one PWM cycle. When the counter reaches that value it returns to zero, the output enters its active level and a one-cycle interrupt pulse is raised. A duty compare value sets the count at which the output goes back to its inactive level. That match does not restart the count.

A new duty value is not applied at once. It is placed in a pending holding register. It moves into the working duty register only when the counter matches the duty value that is still in use. The move also requires that at least three count ticks have passed since the write. A match that comes too early leaves the value pending until the next qualifying match. A new period value is applied at once. A polarity input selects which output level counts as inactive.

Top module: `pwm_buffered_timer`

## Requirements
- R1: After reset the interrupt is 0, the output is at its inactive level, the counter is 00H, the period register is FFH and the working duty register is 00H.
- R2: When run rises, the first count tick is swallowed. The counter stays at 00H through that tick and advances from 00H on the ticks after it. The output stays inactive until the first period match.
- R3: On a counted tick where the counter equals the period value, the counter returns to 00H, the output becomes active and `irq` is high for exactly the next clock cycle.
- R4: On a counted tick where the counter equals the working duty value and not the period value, the output becomes inactive. The counter keeps counting up and no interrupt is raised.
- R5: A duty write (`wr_en` with `wr_sel`=1) stores the data as pending. The working duty register takes the pending value only on a counted tick where the counter matches the old working duty value.
- R6: A pending duty value moves only if at least three run-time count ticks have passed since its write. A match that comes earlier leaves the working value unchanged and the pending value waiting for the next qualifying match.
- R7: While run is 0, the output is inactive, `irq` is 0 and the counter is held at 00H.
- R8: With `polarity`=0 the inactive level is low and the active level is high. With `polarity`=1 both levels are inverted.
- R9: A period write (`wr_en` with `wr_sel`=0) takes effect from the next counted tick, without buffering.
- R10: When the period and duty matches fall on the same tick, the period match takes precedence and the output becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-clock enable, one pulse per count |
| run | input | 1 | Timer enable |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 1 | Write target: 0 selects period, 1 selects duty |
| wr_data | input | 8 | Compare value to write |
| polarity | input | 1 | Inactive-level select |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | One-cycle pulse after each period match |

## Verification
Two functions can land on the same tick: the period match and the duty match, and the duty-register transfer and a fresh duty write. The first is provoked by setting the duty value equal to the period value. The second is provoked by writing a duty value two ticks before the old duty match, and also on the edge of a match itself. A behavioural model in the bench follows the counter, the pending register and the guard-tick count. On every clock it predicts both outputs, so a priority or guard error shows up as a shifted output edge.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_DUTY   = 1'b1
  } wr_target_e;
endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] period_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             step_o,
  output logic             pmatch_o
);
  logic [WIDTH-1:0] cnt_q;
  logic             armed_q;

  assign step_o   = run_i && tick_i && armed_q;
  assign pmatch_o = step_o && (cnt_q == period_i);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (tick_i) begin
      if (!armed_q)      armed_q <= 1'b1;
      else if (pmatch_o) cnt_q   <= '0;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end

  a_r3_clear_on_period: assert property (@(posedge clk) disable iff (!rst_n)
    pmatch_o |=> (cnt_q == '0));
  a_r2_masked_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !armed_q) |=> (cnt_q == '0));
  a_r7_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_duty_buffer.sv
module pwm_duty_buffer #(
  parameter int WIDTH = 8,
  parameter int GUARD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             wr_duty_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             dmatch_o
);
  localparam int AGE_W = $clog2(GUARD + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(GUARD);

  logic [WIDTH-1:0] duty_q, pend_q;
  logic             pend_v;
  logic [AGE_W-1:0] age_q;
  logic             age_ok;

  assign dmatch_o = step_i && (cnt_i == duty_q);
  assign age_ok   = (age_q >= AGE_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
      age_q  <= '0;
    end else begin
      if (dmatch_o && pend_v && age_ok) begin
        duty_q <= pend_q;
        pend_v <= 1'b0;
      end
      if (wr_duty_i) begin
        pend_q <= wr_data_i;
        pend_v <= 1'b1;
        age_q  <= '0;
      end else if (run_i && tick_i && !age_ok) begin
        age_q  <= age_q + 1'b1;
      end
    end
  end

  a_r6_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (dmatch_o && !age_ok) |=> (duty_q == $past(duty_q)));
  a_r5_hold_without_match: assert property (@(posedge clk) disable iff (!rst_n)
    !dmatch_o |=> (duty_q == $past(duty_q)));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic pmatch_i,
  input  logic dmatch_i,
  input  logic polarity_i,
  output logic pwm_o,
  output logic irq_o
);
  logic active_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      active_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= pmatch_i;
      if (pmatch_i)      active_q <= 1'b1;
      else if (dmatch_i) active_q <= 1'b0;
    end
  end

  assign pwm_o = active_q ^ polarity_i;
  assign irq_o = irq_q;

  a_r3_period_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && pmatch_i) |=> (active_q && irq_q));
  a_r4_duty_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && dmatch_i && !pmatch_i) |=> (!active_q && !irq_q));
  a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!active_q && !irq_q));
endmodule

// File: rtl/pwm_buffered_timer.sv
module pwm_buffered_timer #(
  parameter int WIDTH = 8,
  parameter int GUARD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             polarity,
  output logic             pwm_out,
  output logic             irq
);
  import pwm_timer_pkg::*;

  logic [WIDTH-1:0] period_q, cnt;
  logic             step, pmatch, dmatch, wr_duty;

  assign wr_duty = wr_en && (wr_sel == SEL_DUTY);

  always_ff @(posedge clk) begin
    if (!rst_n)                              period_q <= '1;
    else if (wr_en && wr_sel == SEL_PERIOD)  period_q <= wr_data;
  end

  pwm_tick_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
    .period_i(period_q), .cnt_o(cnt), .step_o(step), .pmatch_o(pmatch)
  );

  pwm_duty_buffer #(.WIDTH(WIDTH), .GUARD(GUARD)) u_duty (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick), .step_i(step),
    .cnt_i(cnt), .wr_duty_i(wr_duty), .wr_data_i(wr_data), .dmatch_o(dmatch)
  );

  pwm_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .run_i(run), .pmatch_i(pmatch),
    .dmatch_i(dmatch), .polarity_i(polarity), .pwm_o(pwm_out), .irq_o(irq)
  );

  a_r9_period_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_PERIOD) |=> (period_q == $past(wr_data)));
endmodule

// File: tb/pwm_buffered_timer_tb.sv
module pwm_buffered_timer_tb;
  logic clk = 0, rst_n = 0, tick = 0, run = 0, wr_en = 0, wr_sel = 0, polarity = 0;
  logic [7:0] wr_data = 0;
  logic pwm_out, irq;
  int checks = 0, errors = 0;
  string cur_req = "R1";
  int tick_mode = 0;
  bit tick_phase = 0;
  bit done = 0;

  // behavioural reference
  int m_cnt = 0, m_per = 255, m_duty = 0, m_pend = 0, m_age = 0;
  bit m_armed = 0, m_act = 0, m_irq = 0, m_pv = 0;

  always #10 clk = ~clk;

  pwm_buffered_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .polarity(polarity),
    .pwm_out(pwm_out), .irq(irq)
  );

  always @(posedge clk) begin
    bit step, pm, dm;
    if (!rst_n) begin
      m_cnt = 0; m_per = 255; m_duty = 0; m_pend = 0; m_age = 0;
      m_armed = 0; m_act = 0; m_irq = 0; m_pv = 0;
    end else begin
      step = run && tick && m_armed;
      pm = step && (m_cnt == m_per);
      dm = step && (m_cnt == m_duty);
      if (dm && m_pv && m_age >= 3) begin m_duty = m_pend; m_pv = 0; end
      if (wr_en && wr_sel) begin m_pend = wr_data; m_pv = 1; m_age = 0; end
      else if (run && tick && m_age < 3) m_age++;
      if (!run) begin
        m_cnt = 0; m_armed = 0; m_act = 0; m_irq = 0;
      end else begin
        m_irq = pm;
        if (pm) m_act = 1; else if (dm) m_act = 0;
        if (tick) begin
          if (!m_armed) m_armed = 1;
          else if (pm) m_cnt = 0;
          else m_cnt = (m_cnt + 1) % 256;
        end
      end
      if (wr_en && !wr_sel) m_per = wr_data;
    end
  end

  always @(posedge clk) begin
    #2;
    tick_phase = ~tick_phase;
    tick = (tick_mode == 0) ? 1'b1 : tick_phase;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pwm_out !== (m_act ^ polarity) || irq !== m_irq) begin
        errors++;
        $display("FAIL %s t=%0t pwm_out=%0b irq=%0b expected pwm_out=%0b irq=%0b",
                 cur_req, $time, pwm_out, irq, m_act ^ polarity, m_irq);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic write_reg(input bit sel, input int val);
    @(posedge clk); #2;
    wr_en = 1; wr_sel = sel; wr_data = val[7:0];
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic wait_cnt(input int v);
    int guard_n = 0;
    do begin @(posedge clk); #2; guard_n++; end while (m_cnt != v && guard_n < 2000);
  endtask

  initial begin
    repeat (3000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    #5;
    checks++;
    if (pwm_out !== 1'b0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset pwm_out=%0b irq=%0b expected 0 0", pwm_out, irq);
    end
    cur_req = "R9"; write_reg(0, 9);
    cur_req = "R5"; write_reg(1, 4);
    cur_req = "R2"; run = 1; cyc(5);
    cur_req = "R3"; cyc(30);
    cur_req = "R4"; cyc(30);
    cur_req = "R6"; wait_cnt(2); write_reg(1, 7); cyc(40);
    cur_req = "R5"; wait_cnt(5); write_reg(1, 2); cyc(40);
    cur_req = "R6"; wait_cnt(1); write_reg(1, 6); cyc(40);
    cur_req = "R10"; write_reg(1, 9); cyc(40);
    cur_req = "R9"; write_reg(0, 5); cyc(40);
    cur_req = "R8"; polarity = 1; cyc(30);
    cur_req = "R7"; run = 0; cyc(10);
    cur_req = "R2"; tick_mode = 1; run = 1; cyc(60);
    cur_req = "R6"; write_reg(1, 3); cyc(60);
    cur_req = "R8"; polarity = 0; cyc(30);
    cur_req = "R7"; run = 0; cyc(6);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule